// File: doc/BRIEF.md
# Three-Channel LED Breathing Sequencer

This block turns three LED channels into self-running "breathing" lights. Each channel has a brightness envelope that it plays without any help from software. When breathing is switched on, a channel first waits through a start delay that happens once. It then loops through four phases: a linear rise from dark to its peak, a hold at the peak, a linear fall back to dark, and a dark interval. Each channel has its own five duration codes. The peak brightness is the channel's 8-bit peak input. The output is an 8-bit duty word per channel, which a separate PWM stage turns into pin activity.

Durations are coded on an exponential scale. The base step is 2^UNIT_SHIFT ticks of an external time-base enable, and each code step doubles the time. A ramp mode parks every channel after one pass. Depending on a hold-select bit, the channel stays either lit at its peak or dark. A mark output follows one selected channel. It goes low when that channel's rise ends and goes high again when its fall ends, so a controller knows when a colour update can be applied safely.

Top module: `breath_seq`

## Requirements
- R1: Start-delay and dark-interval codes (4 bits) give 0 ticks for code 0 and 2^(c-1) base steps for code c in 1..10; codes above 10 act as 10. The hold code (4 bits) follows the same rule with a ceiling of 8. One base step is 2^UNIT_SHIFT ticks.
- R2: Rise and fall codes (3 bits) give 2^c base steps for code c, so these phases always last at least one base step.
- R3: After breathing is enabled, each channel runs its start delay once. It then repeats rise, hold, fall, dark. Any phase whose length is zero is skipped, and the start delay is never re-entered until the channel restarts.
- R4: During rise, duty equals floor(peak*e/L), where e counts the ticks since the phase began (0..L-1) and L is the rise length. During fall, duty equals peak - floor(peak*e/L). Hold gives peak. Start delay and dark give 0.
- R5: With ramp mode on and hold-select 0, a channel that finishes its rise stays at peak indefinitely. It enters the hold state even when the hold code is 0.
- R6: With ramp mode on and hold-select 1, a channel runs rise, hold and fall once and then stays at duty 0 indefinitely.
- R7: While the mark is enabled, it falls at the end of the selected channel's rise and rises at the end of its fall. It is registered, so it reads low from the first hold (or fall) cycle through the last fall cycle. Select codes 0, 1 and 2 pick channels 0, 1 and 2; code 3 picks channel 0.
- R8: The mark reads 1 after reset, and in every cycle after a clock edge at which either the mark enable or the breathing enable was 0.
- R9: After a clock edge with breathing off, every duty reads 0. A change to any timing code also forces all duties to 0 for one cycle. In both cases every channel then restarts from its start delay.
- R10: Phase timers advance only on clock edges where the tick input is 1. With tick held at 0, duties and phases stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable; one tick advances phase timers by one |
| breath_en | input | 1 | Breathing on; 0 holds all channels idle at duty 0 |
| ramp_en | input | 1 | Run one pass and park instead of looping |
| hold_sel | input | 1 | Park choice in ramp mode: 0 at peak, 1 dark |
| mark_en | input | 1 | Mark output enable |
| mark_sel | input | 2 | Channel followed by the mark (3 acts as 0) |
| t0_codes | input | 4*NUM_CH | Start-delay code per channel, channel 0 in the low bits |
| t1_codes | input | 3*NUM_CH | Rise code per channel |
| t2_codes | input | 4*NUM_CH | Hold code per channel |
| t3_codes | input | 3*NUM_CH | Fall code per channel |
| t4_codes | input | 4*NUM_CH | Dark-interval code per channel |
| peaks | input | 8*NUM_CH | Peak duty per channel |
| duty | output | 8*NUM_CH | Instantaneous duty per channel |
| mark | output | 1 | Mark following the selected channel |

## Verification
The bench builds the block with UNIT_SHIFT set to 2, so one base step is four ticks. It holds tick at 1 except in the gating test. At this setting the longest 66.56-second-class phase lasts 2048 cycles, which brings the clamped codes, the longest rise and fall, and several whole loops of every channel within a short run. At each step the bench checks duty against floor arithmetic on the code-derived lengths, which also exercises the non-divisible peak values.

// File: rtl/breath_pkg.sv
package breath_pkg;

    // Width of a duration expressed in base steps (longest is 512).
    localparam int UNIT_W = 10;
    localparam logic [3:0] LONG_CAP = 4'd10;
    localparam logic [3:0] HOLD_CAP = 4'd8;

    typedef enum logic [2:0] {
        PH_START,
        PH_OFFSET,
        PH_RISE,
        PH_HOLD,
        PH_FALL,
        PH_OFF
    } phase_t;

    typedef struct packed {
        logic [3:0] t0;
        logic [2:0] t1;
        logic [3:0] t2;
        logic [2:0] t3;
        logic [3:0] t4;
    } times_t;

    localparam int TIMES_W = $bits(times_t);

    // Optional phase: code 0 is empty, code c is 2^(c-1) steps, capped.
    function automatic logic [UNIT_W-1:0] units_opt(input logic [3:0] code,
                                                    input logic [3:0] cap);
        logic [3:0] c;
        c = (code > cap) ? cap : code;
        return (c == 4'd0) ? '0 : (UNIT_W'(1) << (c - 4'd1));
    endfunction

    // Mandatory phase: code c is 2^c steps.
    function automatic logic [UNIT_W-1:0] units_req(input logic [2:0] code);
        return UNIT_W'(1) << code;
    endfunction

endpackage

// File: rtl/breath_channel.sv
module breath_channel
    import breath_pkg::*;
#(
    parameter int UNIT_SHIFT = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  logic       restart,
    input  logic       ramp,
    input  logic       hsel,
    input  times_t     tm,
    input  logic [7:0] peak,
    output logic [7:0] duty,
    output logic       rise_end,
    output logic       fall_end
);
    localparam int CW = UNIT_W + UNIT_SHIFT;

    times_t          tm_q;
    phase_t          ph;
    phase_t          nxt;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   len0, len1, len2, len3, len4, cur_len;
    logic [CW:0]     cnt_nx;
    logic            at_end, parked, live, advance;

    assign len0 = CW'(units_opt(tm_q.t0, LONG_CAP)) << UNIT_SHIFT;
    assign len1 = CW'(units_req(tm_q.t1)) << UNIT_SHIFT;
    assign len2 = CW'(units_opt(tm_q.t2, HOLD_CAP)) << UNIT_SHIFT;
    assign len3 = CW'(units_req(tm_q.t3)) << UNIT_SHIFT;
    assign len4 = CW'(units_opt(tm_q.t4, LONG_CAP)) << UNIT_SHIFT;

    always_comb begin
        case (ph)
            PH_OFFSET: cur_len = len0;
            PH_RISE:   cur_len = len1;
            PH_HOLD:   cur_len = len2;
            PH_FALL:   cur_len = len3;
            PH_OFF:    cur_len = len4;
            default:   cur_len = '0;
        endcase
    end

    // A zero-length phase (only reachable while parked) ends at once.
    assign cnt_nx  = {1'b0, cnt} + 1'b1;
    assign at_end  = tick && (cnt_nx >= {1'b0, cur_len});
    assign parked  = ramp && ((!hsel && ph == PH_HOLD) || (hsel && ph == PH_OFF));
    assign live    = en && !restart;
    assign advance = live && !parked && at_end && (ph != PH_START);

    always_comb begin
        case (ph)
            PH_OFFSET: nxt = PH_RISE;
            PH_RISE:   nxt = (len2 != '0 || (ramp && !hsel)) ? PH_HOLD : PH_FALL;
            PH_HOLD:   nxt = PH_FALL;
            PH_FALL:   nxt = (len4 != '0 || (ramp && hsel)) ? PH_OFF : PH_RISE;
            default:   nxt = PH_RISE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q <= '0;
            ph   <= PH_START;
            cnt  <= '0;
        end else begin
            tm_q <= tm;
            if (!live) begin
                ph  <= PH_START;
                cnt <= '0;
            end else if (ph == PH_START) begin
                ph  <= (len0 != '0) ? PH_OFFSET : PH_RISE;
                cnt <= '0;
            end else if (advance) begin
                ph  <= nxt;
                cnt <= '0;
            end else if (tick && !parked) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Linear ramp: lengths are powers of two, so the division is a shift.
    logic [2:0]      sh_code;
    logic [CW+7:0]   prod, scaled;
    logic [7:0]      ramp_v;

    assign sh_code = (ph == PH_FALL) ? tm_q.t3 : tm_q.t1;
    assign prod    = {{CW{1'b0}}, peak} * {8'b0, cnt};
    assign scaled  = prod >> (UNIT_SHIFT + int'(sh_code));
    assign ramp_v  = scaled[7:0];

    always_comb begin
        case (ph)
            PH_RISE: duty = ramp_v;
            PH_HOLD: duty = peak;
            PH_FALL: duty = peak - ramp_v;
            default: duty = 8'd0;
        endcase
    end

    assign rise_end = advance && (ph == PH_RISE);
    assign fall_end = advance && (ph == PH_FALL);

    // R4: the envelope never exceeds the peak
    assert_duty_bound_R4: assert property (@(posedge clk) disable iff (rst)
        duty <= peak);

    // R5: parked at peak stays there
    assert_park_peak_R5: assert property (@(posedge clk) disable iff (rst)
        (live && ramp && !hsel && ph == PH_HOLD) |=> (ph == PH_HOLD));

    // R6: parked dark stays there
    assert_park_dark_R6: assert property (@(posedge clk) disable iff (rst)
        (live && ramp && hsel && ph == PH_OFF) |=> (ph == PH_OFF));

    // R9: breathing off idles the channel at zero
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ph == PH_START && duty == 8'd0));

    // R3: the start delay is reached only from the idle state
    assert_offset_once_R3: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_START && ph != PH_OFFSET) |=> (ph != PH_OFFSET));

    // R10: no tick, no movement
    assert_tick_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (live && !tick && ph != PH_START) |=> ($stable(cnt) && $stable(ph)));

endmodule

// File: rtl/breath_mark.sv
module breath_mark #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              mark_en,
    input  logic [1:0]        sel,
    input  logic [NUM_CH-1:0] rise_end,
    input  logic [NUM_CH-1:0] fall_end,
    output logic              mark
);
    logic [1:0] idx;
    logic       on;

    assign idx = (32'(sel) >= NUM_CH) ? 2'd0 : sel;
    assign on  = en && mark_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mark <= 1'b1;
        end else if (!on) begin
            mark <= 1'b1;
        end else if (rise_end[idx]) begin
            mark <= 1'b0;
        end else if (fall_end[idx]) begin
            mark <= 1'b1;
        end
    end

    // R8: idle high when disabled
    assert_mark_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !on |=> mark);

    // R7: end of rise drives the mark low
    assert_mark_low_R7: assert property (@(posedge clk) disable iff (rst)
        (on && rise_end[idx]) |=> !mark);

    // R7: end of fall drives the mark high
    assert_mark_high_R7: assert property (@(posedge clk) disable iff (rst)
        (on && fall_end[idx]) |=> mark);

endmodule

// File: rtl/breath_seq.sv
module breath_seq
    import breath_pkg::*;
#(
    parameter int UNIT_SHIFT = 5,
    parameter int NUM_CH     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                breath_en,
    input  logic                ramp_en,
    input  logic                hold_sel,
    input  logic                mark_en,
    input  logic [1:0]          mark_sel,
    input  logic [4*NUM_CH-1:0] t0_codes,
    input  logic [3*NUM_CH-1:0] t1_codes,
    input  logic [4*NUM_CH-1:0] t2_codes,
    input  logic [3*NUM_CH-1:0] t3_codes,
    input  logic [4*NUM_CH-1:0] t4_codes,
    input  logic [8*NUM_CH-1:0] peaks,
    output logic [8*NUM_CH-1:0] duty,
    output logic                mark
);
    localparam int CODE_W = NUM_CH * TIMES_W;

    logic [CODE_W-1:0] codes_now, codes_q;
    logic              restart;
    logic [NUM_CH-1:0] rise_end, fall_end;

    assign codes_now = {t0_codes, t1_codes, t2_codes, t3_codes, t4_codes};
    assign restart   = (codes_now != codes_q);

    always_ff @(posedge clk) begin
        if (rst) codes_q <= '0;
        else     codes_q <= codes_now;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        times_t tm;
        assign tm.t0 = t0_codes[4*g +: 4];
        assign tm.t1 = t1_codes[3*g +: 3];
        assign tm.t2 = t2_codes[4*g +: 4];
        assign tm.t3 = t3_codes[3*g +: 3];
        assign tm.t4 = t4_codes[4*g +: 4];

        breath_channel #(.UNIT_SHIFT(UNIT_SHIFT)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .en       (breath_en),
            .restart  (restart),
            .ramp     (ramp_en),
            .hsel     (hold_sel),
            .tm       (tm),
            .peak     (peaks[8*g +: 8]),
            .duty     (duty[8*g +: 8]),
            .rise_end (rise_end[g]),
            .fall_end (fall_end[g])
        );
    end

    breath_mark #(.NUM_CH(NUM_CH)) u_mark (
        .clk      (clk),
        .rst      (rst),
        .en       (breath_en),
        .mark_en  (mark_en),
        .sel      (mark_sel),
        .rise_end (rise_end),
        .fall_end (fall_end),
        .mark     (mark)
    );

endmodule

// File: tb/tb_breath_seq.sv
`timescale 1ns/1ps
module tb_breath_seq;
    localparam int US  = 2;
    localparam int TPU = 1 << US;
    localparam int N   = 3;

    logic clk = 1'b0;
    logic rst, tick, breath_en, ramp_en, hold_sel, mark_en;
    logic [1:0]     mark_sel;
    logic [4*N-1:0] t0_codes, t2_codes, t4_codes;
    logic [3*N-1:0] t1_codes, t3_codes;
    logic [8*N-1:0] peaks;
    logic [8*N-1:0] duty;
    logic           mark;

    int checks = 0;
    int fails  = 0;
    int c0[N], c1[N], c2[N], c3[N], c4[N], pk[N];

    always #10 clk = ~clk;

    breath_seq #(.UNIT_SHIFT(US), .NUM_CH(N)) dut (
        .clk(clk), .rst(rst), .tick(tick), .breath_en(breath_en),
        .ramp_en(ramp_en), .hold_sel(hold_sel), .mark_en(mark_en),
        .mark_sel(mark_sel), .t0_codes(t0_codes), .t1_codes(t1_codes),
        .t2_codes(t2_codes), .t3_codes(t3_codes), .t4_codes(t4_codes),
        .peaks(peaks), .duty(duty), .mark(mark)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lz(input int code, input int cap);
        int c = (code > cap) ? cap : code;
        return (c == 0) ? 0 : (1 << (c - 1)) * TPU;
    endfunction

    function automatic int lnz(input int code);
        return (1 << code) * TPU;
    endfunction

    function automatic int exp_duty(input int ch, input int t);
        int l0 = lz(c0[ch], 10), l1 = lnz(c1[ch]), l2 = lz(c2[ch], 8);
        int l3 = lnz(c3[ch]), l4 = lz(c4[ch], 10);
        int p = t - l0;
        if (p < 0) return 0;
        if (!ramp_en) p = p % (l1 + l2 + l3 + l4);
        if (p < l1) return pk[ch] * p / l1;
        p -= l1;
        if (ramp_en && !hold_sel) return pk[ch];
        if (p < l2) return pk[ch];
        p -= l2;
        if (p < l3) return pk[ch] - pk[ch] * p / l3;
        return 0;
    endfunction

    function automatic int exp_mark(input int t);
        int s = (mark_sel == 2'd3) ? 0 : int'(mark_sel);
        int l1 = lnz(c1[s]), l2 = lz(c2[s], 8), l3 = lnz(c3[s]);
        int p = t - lz(c0[s], 10);
        if (!mark_en || p < 0) return 1;
        if (ramp_en && !hold_sel) return (p < l1) ? 1 : 0;
        if (!ramp_en) p = p % (l1 + l2 + l3 + lz(c4[s], 10));
        return (p >= l1 && p < l1 + l2 + l3) ? 0 : 1;
    endfunction

    task automatic set_ch(input int ch, input int a, input int b, input int c,
                          input int d, input int e, input int p);
        c0[ch] = a; c1[ch] = b; c2[ch] = c; c3[ch] = d; c4[ch] = e; pk[ch] = p;
        t0_codes[4*ch +: 4] = 4'(a);
        t1_codes[3*ch +: 3] = 3'(b);
        t2_codes[4*ch +: 4] = 4'(c);
        t3_codes[3*ch +: 3] = 3'(d);
        t4_codes[4*ch +: 4] = 4'(e);
        peaks[8*ch +: 8]    = 8'(p);
    endtask

    task automatic base_cfg();
        set_ch(0, 0, 0, 1, 0, 1, 200);
        set_ch(1, 2, 1, 0, 2, 0, 255);
        set_ch(2, 1, 2, 2, 1, 3, 37);
    endtask

    // Caller is at a negedge with configuration applied.
    task automatic start_run();
        breath_en = 1'b0;
        @(negedge clk);
        breath_en = 1'b1;
    endtask

    task automatic run_cmp(input int t_start, input int n, input string req);
        int bad_d = 0, bad_m = 0, ad = 0, ed = 0, am = 0, em = 0;
        for (int t = t_start; t < t_start + n; t++) begin
            @(negedge clk);
            for (int ch = 0; ch < N; ch++) begin
                int e = exp_duty(ch, t);
                if (int'(duty[8*ch +: 8]) != e && bad_d == 0) begin
                    bad_d = 1; ad = int'(duty[8*ch +: 8]); ed = e;
                    $display("  duty mismatch t=%0d ch=%0d", t, ch);
                end
            end
            if (int'(mark) != exp_mark(t) && bad_m == 0) begin
                bad_m = 1; am = int'(mark); em = exp_mark(t);
                $display("  mark mismatch t=%0d", t);
            end
        end
        check(bad_d == 0, {req, " duty"}, ad, ed);
        check(bad_m == 0, {req, " mark"}, am, em);
    endtask

    task automatic all_zero(input string req);
        for (int ch = 0; ch < N; ch++)
            check(duty[8*ch +: 8] == 8'd0, req, int'(duty[8*ch +: 8]), 0);
    endtask

    task automatic t_reset();
        all_zero("R9 reset");
        check(mark == 1'b1, "R8 reset", int'(mark), 1);
    endtask

    task automatic t_free_run();   // R3 R4 R1
        base_cfg(); ramp_en = 0; mark_en = 1; mark_sel = 2'd1;
        start_run();
        run_cmp(0, 200, "R3");
        mark_sel = 2'd2; start_run();
        run_cmp(0, 150, "R4");
    endtask

    task automatic t_mark_sel();   // R7 code 3 -> channel 0
        base_cfg(); mark_sel = 2'd3; start_run();
        run_cmp(0, 100, "R7");
        mark_sel = 2'd0; start_run();
        run_cmp(0, 60, "R7");
    endtask

    task automatic t_ramp_hold();  // R5, including zero hold code on channel 1
        base_cfg(); ramp_en = 1; hold_sel = 0; mark_sel = 2'd1; start_run();
        run_cmp(0, 200, "R5");
    endtask

    task automatic t_ramp_dark();  // R6, including zero dark code on channel 1
        base_cfg(); ramp_en = 1; hold_sel = 1; mark_sel = 2'd2; start_run();
        run_cmp(0, 250, "R6");
        ramp_en = 0;
    endtask

    task automatic t_mark_off();   // R8
        base_cfg(); mark_en = 0; mark_sel = 2'd0; start_run();
        run_cmp(0, 80, "R8");
        mark_en = 1;
    endtask

    task automatic t_disable();    // R9
        base_cfg(); mark_sel = 2'd0; start_run();
        run_cmp(0, 10, "R9");
        breath_en = 0;
        @(negedge clk);
        all_zero("R9 off");
        check(mark == 1'b1, "R8 off", int'(mark), 1);
        breath_en = 1;
        run_cmp(0, 60, "R9");
    endtask

    task automatic t_code_change(); // R9 restart on new code
        base_cfg(); mark_sel = 2'd0; start_run();
        run_cmp(0, 30, "R9");
        set_ch(2, 0, 1, 1, 1, 1, 90);
        @(negedge clk);
        all_zero("R9 change");
        run_cmp(0, 80, "R9");
    endtask

    task automatic t_tick_gate();  // R10
        int held;
        base_cfg(); mark_sel = 2'd2; start_run();
        run_cmp(0, 6, "R10");
        tick = 0;
        held = int'(duty[8*2 +: 8]);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(int'(duty[8*2 +: 8]) == held && int'(duty[7:0]) == exp_duty(0, 5),
                  "R10 frozen", int'(duty[8*2 +: 8]), held);
        end
        tick = 1;
        run_cmp(6, 80, "R10");
    endtask

    task automatic t_clamp();      // R1 caps, R2 longest ramps
        set_ch(0, 15, 0, 0, 0, 0, 77);
        set_ch(1, 0, 0, 15, 0, 0, 128);
        set_ch(2, 0, 0, 0, 0, 12, 250);
        mark_sel = 2'd1; start_run();
        run_cmp(0, 2200, "R1");
        set_ch(0, 0, 7, 0, 0, 0, 255);
        set_ch(1, 0, 0, 0, 7, 0, 133);
        set_ch(2, 3, 5, 3, 6, 0, 99);
        mark_sel = 2'd0; start_run();
        run_cmp(0, 1200, "R2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1; tick = 1; breath_en = 0; ramp_en = 0; hold_sel = 0;
        mark_en = 1; mark_sel = 0;
        t0_codes = '0; t1_codes = '0; t2_codes = '0; t3_codes = '0;
        t4_codes = '0; peaks = '0;
        base_cfg();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_free_run();
        t_mark_sel();
        t_ramp_hold();
        t_ramp_dark();
        t_mark_off();
        t_disable();
        t_code_change();
        t_tick_gate();
        t_clamp();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule